// File: doc/BRIEF.md
# Audio PCM-to-PWM Bridge Modulator

This block turns a stream of unsigned 12-bit audio samples into two complementary pulse-width-modulated signals that drive the two legs of a full-bridge switching output stage. A free-running 10-bit counter defines a PWM period of 1024 system clocks. At a 100 MHz clock this gives a period rate of about 97.656 kHz, and the audio sample rate is locked to it: one sample is consumed per period.

When the counter wraps, the block pulses a one-clock request strobe. The upstream source answers with a sample on a valid/data pair. The block keeps the upper ten bits of the sample as the compare value and holds it in a shadow register. The shadow value becomes the active compare value only at the next wrap, so a period's waveform never changes partway through. If no sample arrives during a period, the previous value simply repeats. After reset the compare value is 512, which gives a 50% duty square wave: silence on the bridge.

Top module: `pcm_pwm_modulator`

## Requirements
- R1: The period counter counts 0, 1, ..., 1023 and then returns to 0, so every PWM period lasts exactly 1024 clocks.
- R2: `smp_req` is high for exactly one clock: the first cycle (count 0) of every period that follows a wrap. It stays low from reset until the first wrap.
- R3: The compare value is `smp_data[11:2]`, i.e. the sample shifted right by two. The two low sample bits have no effect on the output.
- R4: `drive_p` is high in the cycles of a period whose count is below the active compare value and low in the rest. It is therefore high for the first `cmp` cycles, and the duty cycle is cmp/1024 (a compare value of 512 gives 50%).
- R5: `drive_n` is the exact complement of `drive_p` in every cycle.
- R6: A sample accepted during a period does not alter that period's waveform. It becomes active in the first cycle of the next period.
- R7: If no sample is accepted during a period, the next period repeats the previous compare value. If several samples are accepted in one period, the last one is used.
- R8: Synchronous active-low reset sets the count to 0 and both the shadow and the active compare value to 512.
- R9: A compare value of 0 (samples 0 to 3) keeps `drive_p` low for the whole period. A compare value of 1023 (samples 4092 to 4095) keeps it high for all cycles except count 1023.
- R10: A sample accepted in the last cycle of a period (count 1023) reaches only the shadow register. The following period still uses the earlier shadow value, and the new value takes effect one period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample on `smp_data` is accepted this cycle |
| smp_data | input | 12 | Unsigned audio sample, 0 to 4095 |
| smp_req | output | 1 | One-clock request for the next sample, at the start of a period |
| drive_p | output | 1 | PWM drive for the positive bridge leg |
| drive_n | output | 1 | Complementary PWM drive for the negative bridge leg |

## Verification
The bench checks every cycle of each period against a pulse width computed from the sample it sent. This exposes a design that updates the compare value mid-period (a split pulse), shifts by the wrong amount (the pulse width is off by a factor of two or more), or lets the two low bits leak (4092 and 4095 give different widths). The extremes 0 and 4095 catch an off-by-one comparator: such a design would emit a one-cycle sliver at zero, or run high through count 1023. The bench also skips a sample, sends two samples in one period, and sends a sample in the wrap cycle. A design that clears the compare value when no sample arrives, keeps the first of two samples, or passes a wrap-cycle sample straight to the active register would produce the wrong width in the following period.

// File: rtl/pcm_pwm_pkg.sv
// Package: shared default sizes for the PCM-to-PWM modulator.
// Assumes: sample width is at least the counter width.
package pcm_pwm_pkg;
    localparam int unsigned DEF_SAMPLE_W = 12;
    localparam int unsigned DEF_CNT_W    = 10;
endpackage

// File: rtl/pwm_period_counter.sv
// Module: pwm_period_counter
// Free-running period counter. It flags the last cycle of each period and
// registers a one-clock request strobe that is high in the first cycle after
// each wrap.
// Assumes: synchronous active-low reset; the period is 2**CNT_W clocks.
module pwm_period_counter #(
    parameter int unsigned CNT_W = pcm_pwm_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             req
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Last cycle of the period.
    always_comb wrap = (cnt == CNT_MAX);

    // Advance the counter; it rolls over naturally at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Request strobe: set for exactly the cycle after a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= wrap;
    end

    p_wrap_to_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cnt == '0));
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
    p_req_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (cnt == '0));
    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
endmodule

// File: rtl/pwm_compare_shadow.sv
// Module: pwm_compare_shadow
// Scales each accepted sample to a compare value by dropping its low bits,
// keeps it in a shadow register, and copies the shadow to the active compare
// register only in the wrap cycle.
// Assumes: wrap is high in the last cycle of each period; the last sample
// accepted in a period wins.
module pwm_compare_shadow #(
    parameter int unsigned SAMPLE_W = pcm_pwm_pkg::DEF_SAMPLE_W,
    parameter int unsigned CNT_W    = pcm_pwm_pkg::DEF_CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                wrap,
    output logic [CNT_W-1:0]    cmp_active
);
    localparam int unsigned      SHIFT   = SAMPLE_W - CNT_W;
    localparam logic [CNT_W-1:0] CMP_MID = CNT_W'(1) << (CNT_W - 1);

    logic [CNT_W-1:0] cmp_shadow;
    logic [CNT_W-1:0] cmp_scaled;

    // Keep the upper bits of the sample as the compare value.
    always_comb cmp_scaled = smp_data[SAMPLE_W-1:SHIFT];

    // Shadow register: captures every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)         cmp_shadow <= CMP_MID;
        else if (smp_valid) cmp_shadow <= cmp_scaled;
    end

    // Active register: takes the shadow value only in the wrap cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    cmp_active <= CMP_MID;
        else if (wrap) cmp_active <= cmp_shadow;
    end

    p_active_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(cmp_active));
    p_wrap_sample_deferred_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && smp_valid) |=> (cmp_active == $past(cmp_shadow)));
    p_no_sample_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(cmp_shadow));
endmodule

// File: rtl/pwm_bridge_driver.sv
// Module: pwm_bridge_driver
// Compares the period count with the active compare value and drives a
// complementary pair for the two legs of a full bridge.
// Assumes: cnt and cmp_active both come from registers, so the outputs
// change only after clock edges.
module pwm_bridge_driver #(
    parameter int unsigned CNT_W = pcm_pwm_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_active,
    output logic             drive_p,
    output logic             drive_n
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic leg_on;

    // Positive leg is on while the count is below the compare value.
    always_comb leg_on = (cnt < cmp_active);

    // Drive the bridge legs as an exact complementary pair.
    always_comb begin
        drive_p = leg_on;
        drive_n = ~leg_on;
    end

    p_complement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drive_n != drive_p);
    p_zero_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_active == '0) |-> !drive_p);
    p_top_last_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |-> !drive_p);
    p_period_start_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == '0) && (cmp_active != '0)) |-> drive_p);
endmodule

// File: rtl/pcm_pwm_modulator.sv
// Module: pcm_pwm_modulator (top)
// Audio PCM-to-PWM modulator for a full-bridge output stage. It takes one
// unsigned sample per PWM period on request and turns it into a
// complementary pair of pulse-width-modulated drives.
// Assumes: samples arrive on smp_valid after smp_req; the PWM period is
// 2**CNT_W clocks.
module pcm_pwm_modulator #(
    parameter int unsigned SAMPLE_W = pcm_pwm_pkg::DEF_SAMPLE_W,
    parameter int unsigned CNT_W    = pcm_pwm_pkg::DEF_CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                smp_req,
    output logic                drive_p,
    output logic                drive_n
);
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic [CNT_W-1:0] cmp_active;

    pwm_period_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt),
        .wrap  (wrap),
        .req   (smp_req)
    );

    pwm_compare_shadow #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .wrap       (wrap),
        .cmp_active (cmp_active)
    );

    pwm_bridge_driver #(.CNT_W(CNT_W)) u_driver (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt        (cnt),
        .cmp_active (cmp_active),
        .drive_p    (drive_p),
        .drive_n    (drive_n)
    );

    p_reset_state_r8: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0) && (cmp_active == (CNT_W'(1) << (CNT_W - 1))));
endmodule

// File: tb/pcm_pwm_modulator_test.sv
module pcm_pwm_modulator_test;
    localparam int PERIOD = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        smp_req, drive_p, drive_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    pcm_pwm_modulator uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_req(smp_req), .drive_p(drive_p), .drive_n(drive_n)
    );

    always #10 clk = ~clk;

    function automatic int exp_cmp(input int sample);
        return (sample & 4095) >> 2;
    endfunction

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Run one period from count 0 and check every cycle of it. Samples are
    // offered at positions p0 and p1 (-1 means none).
    task automatic run_period(input int cmp, input bit first, input int p0, input int d0,
                              input int p1, input int d1, input string tag);
        int bad = 0;
        int bad_p = -1;
        int bad_v = 0;
        for (int i = 0; i < PERIOD; i++) begin
            if (i == p0)      begin smp_valid = 1'b1; smp_data = 12'(d0); end
            else if (i == p1) begin smp_valid = 1'b1; smp_data = 12'(d1); end
            else              smp_valid = 1'b0;
            if (drive_p !== (i < cmp) || drive_n !== !(i < cmp) ||
                (i > 0 && smp_req !== 1'b0) || (i == 0 && smp_req !== !first)) begin
                if (bad == 0) begin bad_p = i; bad_v = {smp_req, drive_p, drive_n}; end
                bad++;
            end
            @(negedge clk);
        end
        smp_valid = 1'b0;
        checks++;
        if (bad != 0) begin
            failures++;
            $display("FAIL %s: cmp=%0d first bad count=%0d {req,p,n}=%b expected p=%0d",
                     tag, cmp, bad_p, bad_v[2:0], (bad_p < cmp));
        end
        checks++;
        if (smp_req !== 1'b1) begin
            failures++;
            $display("FAIL R2 %s: smp_req at period start=%b expected 1", tag, smp_req);
        end
    endtask

    initial begin
        int cur;
        int v;
        v = $urandom(32'd1234);
        repeat (4) @(negedge clk);
        // R8 reset state: outputs at count 0 with compare 512
        checks++;
        if (smp_req !== 1'b0 || drive_p !== 1'b1 || drive_n !== 1'b0) begin
            failures++;
            $display("FAIL R8 reset: {req,p,n}=%b%b%b expected 010", smp_req, drive_p, drive_n);
        end
        rst_n = 1'b1;
        // R8/R2/R4: first period is 50% with no request; R3 sample of 2048 sent
        run_period(512, 1'b1, 5, 2048, -1, 0, "R8_R4 reset period");
        run_period(exp_cmp(2048), 1'b0, 7, 0, -1, 0, "R3_R4 sample 2048");
        // R9 zero compare; next sample 4095
        run_period(0, 1'b0, 3, 4095, -1, 0, "R9 sample 0");
        // R9 top compare; R3 low bits: send 4092 next (same compare)
        run_period(1023, 1'b0, 9, 4092, -1, 0, "R9 sample 4095");
        run_period(exp_cmp(4092), 1'b0, 2, 3, -1, 0, "R3 sample 4092");
        // R3: sample 3 drops to 0; then 4 gives 1
        run_period(0, 1'b0, 1, 4, -1, 0, "R3 sample 3");
        run_period(1, 1'b0, -1, 0, -1, 0, "R3 sample 4");
        // R7 no sample: previous value repeats
        run_period(1, 1'b0, 200, 1000, 600, 3000, "R7 hold");
        // R7 two samples: last one wins
        run_period(exp_cmp(3000), 1'b0, 1023, 400, -1, 0, "R7 last wins");
        // R10 wrap-cycle sample deferred one period (shadow still 3000)
        run_period(exp_cmp(3000), 1'b0, -1, 0, -1, 0, "R10 deferred");
        run_period(exp_cmp(400), 1'b0, -1, 0, -1, 0, "R10 applied");
        // R6: random samples sent mid-period take effect next period
        cur = exp_cmp(400);
        for (int k = 0; k < 20; k++) begin
            int s;
            int pos;
            s = $urandom % 4096;
            pos = 1 + ($urandom % 1000);
            run_period(cur, 1'b0, pos, s, -1, 0, "R6_R4_R5 random");
            cur = exp_cmp(s);
        end
        run_period(cur, 1'b0, -1, 0, -1, 0, "R6_R4_R5 random last");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule